// File: doc/BRIEF.md
# Tiled Mip Pyramid Reducer

The block builds a full mip pyramid of a square 8-bit unsigned image. It does this one tile at a time. After a start pulse it walks the tiles in raster order. Each tile is fetched once through a memory read port and folded by 2x2 rounded averaging until one value is left. Every intermediate level is sent out on a write port, tagged with its level number and a row-major address inside that level.

A finish counter counts completed tiles. The tile that brings this count to the number of tiles carries on. It treats the grid of per-tile results as a fresh tile and reduces it through the remaining levels down to 1x1. An image no larger than one tile skips this last pass. The done pulse comes only after the top 1x1 level has been written.

Tile edge and image edge are parameters and must be powers of two. Level 1 is half the image edge, and level `log2(IMG)` is the single value at the top.

Top module: `mip_tile_reducer`

## Requirements
- R1: Each output value is (a+b+c+d+2)>>2 of its four source values: level 1 from image pixels, each higher level from the level below. The sum is kept at 10 bits, so halves round up.
- R2: Saturated input (all pixels 255) gives 255 on every level, with no wrap in the sum.
- R3: Tiles are processed in raster order of the tile grid. Each tile emits levels 1 through log2(TILE), lowest level first and raster order within a level, before the next tile starts.
- R4: Every write carries `wr_level` (1 = half-size level) and `wr_addr` = row*(IMG>>level)+column, the row-major position of the value in the full image's level.
- R5: After the last tile finishes, levels log2(TILE)+1 through log2(IMG) are emitted in raster order. They are computed from the per-tile results of the current frame, never from an earlier frame.
- R6: `done` is a single-cycle pulse in the cycle right after the write of the top 1x1 level. `busy` falls in that same cycle, and no write happens while `busy` is low.
- R7: `start` is ignored while `busy` is high. The sequence and number of writes of the running frame do not change.
- R8: After reset, `busy`, `done`, `rd_en` and `wr_en` are low.
- R9: Each frame reads every image pixel through the read port exactly once. Read data is expected one cycle after `rd_en`, and reads only happen while `busy` is high.
- R10: When the image edge equals the tile edge, no grid pass runs. Only levels 1 through log2(TILE) are written, and `done` follows the 1x1 write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame when idle |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse once the top level is written |
| rd_en | output | 1 | Image read request |
| rd_addr | output | log2(IMG*IMG) | Row-major pixel address of the image |
| rd_data | input | 8 | Pixel value, valid one cycle after rd_en |
| wr_en | output | 1 | Output value valid |
| wr_level | output | log2(log2(IMG)+1) | Mip level of the written value |
| wr_addr | output | log2(IMG*IMG)-2 | Row-major address inside that level |
| wr_data | output | 8 | Reduced value |

## Verification
A smooth ramp checks address placement and averaging over varied sums. A fully saturated image exposes a narrow or wrapping sum. A sparse pattern whose 2x2 sums leave a remainder of two or three separates rounding from truncation. Two different pseudo-random frames, run back to back, show whether the grid pass reads the current frame's tile results or stale ones; a start pulse in the middle of the first of these checks that it is ignored. A second instance, whose image is one tile in size, confirms that the grid pass is skipped.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
  localparam int PIX_W = 8;
  localparam int SUM_W = PIX_W + 2;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [SUM_W-1:0] sum_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;
  typedef enum logic [1:0] {SRC_EXT, SRC_SCR, SRC_GRID} src_e;

  // four-way mean with a half-step bias before the divide
  function automatic pix_t round_quarter(input sum_t s);
    sum_t t;
    t = s + sum_t'(2);
    return t[SUM_W-1:2];
  endfunction
endpackage

// File: rtl/mtr_ram.sv
module mtr_ram
  import mtr_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  pix_t          wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output pix_t          rdata
);
  localparam int DEPTH = 2 ** AW;

  pix_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mtr_accum.sv
module mtr_accum
  import mtr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic add,
  input  pix_t din,
  output pix_t avg
);
  sum_t acc_q;

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (load) acc_q <= sum_t'(din);
    else if (add)  acc_q <= acc_q + sum_t'(din);
  end

  assign avg = round_quarter(acc_q);
endmodule

// File: rtl/mtr_ctrl.sv
module mtr_ctrl
  import mtr_pkg::*;
#(
  parameter int TILE = 8,
  parameter int IMG  = 32,
  localparam int LT    = $clog2(TILE),
  localparam int GRID  = IMG / TILE,
  localparam int LG    = $clog2(GRID),
  localparam int NT    = GRID * GRID,
  localparam int AW    = $clog2(IMG * IMG),
  localparam int OAW   = AW - 2,
  localparam int TOPL  = LT + LG,
  localparam int LVW   = $clog2(TOPL + 1),
  localparam int SAW   = (LT > 1) ? 2 * (LT - 1) : 1,
  localparam int GAW   = (LG > 0) ? 2 * LG : 1,
  localparam int IW    = (SAW > GAW) ? SAW : GAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           busy,
  output logic           done,
  // read issue, registered; one address serves all sources
  output logic           ext_re,
  output logic           scr_re,
  output logic           grd_re,
  output logic [AW-1:0]  raddr,
  output src_e           src_dly,
  // accumulator control
  output logic           acc_load,
  output logic           acc_add,
  input  pix_t           avg,
  // internal write-back, using the registered output value
  output logic           scr_we,
  output logic           grd_we,
  output logic [IW-1:0]  iw_addr,
  // output stream
  output logic           wr_en,
  output logic [LVW-1:0] wr_level,
  output logic [OAW-1:0] wr_addr,
  output pix_t           wr_data
);
  localparam int CW  = $clog2(IMG) + 1;
  localparam int TIW = $clog2(NT) + 1;

  state_e           state_q;
  logic             grid_pass_q;
  logic [TIW-1:0]   tile_q;
  logic [TIW-1:0]   fin_cnt_q;
  logic [LVW-1:0]   lvl_q;
  logic [CW-1:0]    ox_q, oy_q;
  logic [2:0]       ph_q;
  logic             busy_q, done_q;
  logic             ext_re_q, scr_re_q, grd_re_q;
  logic [AW-1:0]    raddr_q;
  src_e             src_q, src_d;
  logic             wr_en_q, scr_we_q, grd_we_q;
  logic [LVW-1:0]   wr_level_q;
  logic [OAW-1:0]   wr_addr_q;
  logic [IW-1:0]    iw_addr_q;
  pix_t             wr_data_q;

  // address arithmetic for the current output value
  int   lv, ex, last_lv, t, tx, ty, ox, oy, sx, sy;
  int   a_rd, a_out, a_int;
  src_e src_n;
  logic to_grid;
  logic running;

  assign running = (state_q == ST_RUN);

  always_comb begin
    lv      = int'(lvl_q);
    ox      = int'(ox_q);
    oy      = int'(oy_q);
    t       = int'(tile_q);
    tx      = t % GRID;
    ty      = t / GRID;
    ex      = (grid_pass_q ? GRID : TILE) >> lv;
    last_lv = grid_pass_q ? LG : LT;
    sx      = 2 * ox + int'(ph_q[0]);
    sy      = 2 * oy + int'(ph_q[1]);
    if (!grid_pass_q && lv == 1) begin
      src_n = SRC_EXT;
      a_rd  = (ty * TILE + sy) * IMG + tx * TILE + sx;
    end else if (!grid_pass_q) begin
      src_n = SRC_SCR;
      a_rd  = sy * (2 * ex) + sx;
    end else begin
      src_n = SRC_GRID;
      a_rd  = sy * (2 * ex) + sx;
    end
    if (grid_pass_q) begin
      a_out   = oy * ex + ox;
      a_int   = oy * ex + ox;
      to_grid = 1'b1;
    end else begin
      a_out   = (ty * ex + oy) * (IMG >> lv) + tx * ex + ox;
      to_grid = (lv == LT);
      a_int   = to_grid ? t : (oy * ex + ox);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      grid_pass_q <= 1'b0;
      tile_q      <= '0;
      fin_cnt_q   <= '0;
      lvl_q       <= LVW'(1);
      ox_q        <= '0;
      oy_q        <= '0;
      ph_q        <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      ext_re_q    <= 1'b0;
      scr_re_q    <= 1'b0;
      grd_re_q    <= 1'b0;
      raddr_q     <= '0;
      src_q       <= SRC_EXT;
      src_d       <= SRC_EXT;
      wr_en_q     <= 1'b0;
      scr_we_q    <= 1'b0;
      grd_we_q    <= 1'b0;
      wr_level_q  <= '0;
      wr_addr_q   <= '0;
      iw_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      done_q   <= 1'b0;
      wr_en_q  <= 1'b0;
      scr_we_q <= 1'b0;
      grd_we_q <= 1'b0;
      ext_re_q <= running && (ph_q <= 3'd3) && (src_n == SRC_EXT);
      scr_re_q <= running && (ph_q <= 3'd3) && (src_n == SRC_SCR);
      grd_re_q <= running && (ph_q <= 3'd3) && (src_n == SRC_GRID);
      raddr_q  <= AW'(a_rd);
      src_q    <= src_n;
      src_d    <= src_q;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q     <= ST_RUN;
            busy_q      <= 1'b1;
            grid_pass_q <= 1'b0;
            tile_q      <= '0;
            fin_cnt_q   <= '0;
            lvl_q       <= LVW'(1);
            ox_q        <= '0;
            oy_q        <= '0;
            ph_q        <= '0;
          end
        end
        ST_RUN: begin
          if (ph_q != 3'd6) begin
            ph_q <= ph_q + 3'd1;
          end else begin
            ph_q       <= '0;
            wr_en_q    <= 1'b1;
            wr_level_q <= grid_pass_q ? LVW'(LT + lv) : LVW'(lv);
            wr_addr_q  <= OAW'(a_out);
            wr_data_q  <= avg;
            iw_addr_q  <= IW'(a_int);
            grd_we_q   <= to_grid;
            scr_we_q   <= !to_grid;
            if (ox != ex - 1) begin
              ox_q <= ox_q + CW'(1);
            end else begin
              ox_q <= '0;
              if (oy != ex - 1) begin
                oy_q <= oy_q + CW'(1);
              end else begin
                oy_q <= '0;
                if (lv != last_lv) begin
                  lvl_q <= lvl_q + LVW'(1);
                end else begin
                  lvl_q <= LVW'(1);
                  if (grid_pass_q) begin
                    state_q <= ST_FIN;
                  end else begin
                    fin_cnt_q <= fin_cnt_q + TIW'(1);
                    if (int'(fin_cnt_q) + 1 == NT) begin
                      if (NT > 1) grid_pass_q <= 1'b1;
                      else        state_q     <= ST_FIN;
                    end else begin
                      tile_q <= tile_q + TIW'(1);
                    end
                  end
                end
              end
            end
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign ext_re   = ext_re_q;
  assign scr_re   = scr_re_q;
  assign grd_re   = grd_re_q;
  assign raddr    = raddr_q;
  assign src_dly  = src_d;
  assign acc_load = running && (ph_q == 3'd2);
  assign acc_add  = running && (ph_q >= 3'd3) && (ph_q <= 3'd5);
  assign scr_we   = scr_we_q;
  assign grd_we   = grd_we_q;
  assign iw_addr  = iw_addr_q;
  assign wr_en    = wr_en_q;
  assign wr_level = wr_level_q;
  assign wr_addr  = wr_addr_q;
  assign wr_data  = wr_data_q;
endmodule

// File: rtl/mip_tile_reducer.sv
module mip_tile_reducer
  import mtr_pkg::*;
#(
  parameter int TILE = 8,
  parameter int IMG  = 32,
  localparam int AW   = $clog2(IMG * IMG),
  localparam int OAW  = AW - 2,
  localparam int TOPL = $clog2(IMG),
  localparam int LVW  = $clog2(TOPL + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  input  logic [7:0]     rd_data,
  output logic           wr_en,
  output logic [LVW-1:0] wr_level,
  output logic [OAW-1:0] wr_addr,
  output logic [7:0]     wr_data
);
  localparam int LT  = $clog2(TILE);
  localparam int LG  = $clog2(IMG / TILE);
  localparam int SAW = (LT > 1) ? 2 * (LT - 1) : 1;
  localparam int GAW = (LG > 0) ? 2 * LG : 1;
  localparam int IW  = (SAW > GAW) ? SAW : GAW;

  logic          scr_re, grd_re, scr_we, grd_we;
  logic          acc_load, acc_add;
  logic [AW-1:0] raddr;
  logic [IW-1:0] iw_addr;
  src_e          src_dly;
  pix_t          avg, scr_rdata, grd_rdata, src_pix;

  mtr_ctrl #(.TILE(TILE), .IMG(IMG)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ext_re   (rd_en),
    .scr_re   (scr_re),
    .grd_re   (grd_re),
    .raddr    (raddr),
    .src_dly  (src_dly),
    .acc_load (acc_load),
    .acc_add  (acc_add),
    .avg      (avg),
    .scr_we   (scr_we),
    .grd_we   (grd_we),
    .iw_addr  (iw_addr),
    .wr_en    (wr_en),
    .wr_level (wr_level),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  assign rd_addr = raddr;

  // per-tile working levels, overwritten in place level by level
  mtr_ram #(.AW(SAW)) u_scratch (
    .clk   (clk),
    .we    (scr_we),
    .waddr (iw_addr[SAW-1:0]),
    .wdata (wr_data),
    .re    (scr_re),
    .raddr (raddr[SAW-1:0]),
    .rdata (scr_rdata)
  );

  // one value per tile, then the grid pass works in place on it
  mtr_ram #(.AW(GAW)) u_grid (
    .clk   (clk),
    .we    (grd_we),
    .waddr (iw_addr[GAW-1:0]),
    .wdata (wr_data),
    .re    (grd_re),
    .raddr (raddr[GAW-1:0]),
    .rdata (grd_rdata)
  );

  always_comb begin
    unique case (src_dly)
      SRC_EXT: src_pix = rd_data;
      SRC_SCR: src_pix = scr_rdata;
      default: src_pix = grd_rdata;
    endcase
  end

  mtr_accum u_accum (
    .clk  (clk),
    .rst  (rst),
    .load (acc_load),
    .add  (acc_add),
    .din  (src_pix),
    .avg  (avg)
  );
endmodule

// File: rtl/mip_tile_reducer_chk.sv
module mip_tile_reducer_chk #(
  parameter int TILE = 8,
  parameter int IMG  = 32,
  localparam int TOPL = $clog2(IMG),
  localparam int LVW  = $clog2(TOPL + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           rd_en,
  input logic           wr_en,
  input logic [LVW-1:0] wr_level
);
  // R6: done only right after the top-level write
  a_r6_done_after_top: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(wr_en) && $past(wr_level) == LVW'(TOPL)));

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: no write outside a frame
  a_r6_write_in_frame: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  // R9: no read outside a frame
  a_r9_read_in_frame: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);

  // R7: a frame begins only from a start seen while idle
  a_r7_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && !$past(busy)));

  // R4: level tag stays inside the pyramid
  a_r4_level_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_level >= LVW'(1) && wr_level <= LVW'(TOPL)));
endmodule

bind mip_tile_reducer mip_tile_reducer_chk #(.TILE(TILE), .IMG(IMG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .wr_level (wr_level)
);

// File: tb/test_mip_tile_reducer.sv
module test_mip_tile_reducer;
  localparam int CLK_NS = 10;
  localparam int TILE   = 8;
  localparam int IMG    = 32;
  localparam int LT     = $clog2(TILE);
  localparam int GR     = IMG / TILE;
  localparam int NT     = GR * GR;
  localparam int TOPL   = $clog2(IMG);
  localparam int NPIX   = IMG * IMG;
  localparam int AW     = $clog2(NPIX);
  localparam int LVW    = $clog2(TOPL + 1);
  localparam int LVW1   = $clog2(LT + 1);
  localparam int AW1    = 2 * LT;
  localparam int Q1     = NPIX / 4;
  localparam int T1     = TILE * TILE / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic start1 = 1'b0;

  logic           busy, done, rd_en, wr_en;
  logic [AW-1:0]  rd_addr;
  logic [7:0]     rd_data, wr_data;
  logic [LVW-1:0] wr_level;
  logic [AW-3:0]  wr_addr;

  logic            busy1, done1, rd_en1, wr_en1;
  logic [AW1-1:0]  rd_addr1;
  logic [7:0]      rd_data1, wr_data1;
  logic [LVW1-1:0] wr_level1;
  logic [AW1-3:0]  wr_addr1;

  logic [7:0]  img [NPIX];
  int          pyr  [1:TOPL][Q1];
  int          pyr1 [1:LT][T1];
  logic [31:0] expq[$];
  logic [31:0] expq1[$];
  logic [31:0] e_m, e_m1;
  bit          rdseen [NPIX];

  int    checks = 0, fails = 0;
  int    nwr = 0, nwr1 = 0, nrd = 0, dupr = 0, ndone = 0, ndone1 = 0;
  bit    prev_top = 1'b0, prev_top1 = 1'b0;
  bit    wd = 1'b0;
  int    seed = 32'h1234_5678;
  string dtag = "R1";

  always #(CLK_NS / 2) clk = ~clk;

  mip_tile_reducer #(.TILE(TILE), .IMG(IMG)) i_mip_tile_reducer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_level(wr_level), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  mip_tile_reducer #(.TILE(TILE), .IMG(TILE)) i_mip_tile_reducer_one (
    .clk(clk), .rst(rst), .start(start1), .busy(busy1), .done(done1),
    .rd_en(rd_en1), .rd_addr(rd_addr1), .rd_data(rd_data1),
    .wr_en(wr_en1), .wr_level(wr_level1), .wr_addr(wr_addr1), .wr_data(wr_data1)
  );

  // image memories with one cycle of read latency
  always @(posedge clk) begin
    if (rd_en)  rd_data  <= img[rd_addr];
    if (rd_en1) rd_data1 <= img[rd_addr1];
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int avg4(input int a, input int b, input int c, input int d);
    return (a + b + c + d + 2) / 4;
  endfunction

  function automatic int px(input int l, input int idx);
    return (l == 0) ? int'(img[idx]) : pyr[l][idx];
  endfunction

  function automatic int px1(input int l, input int idx);
    return (l == 0) ? int'(img[idx]) : pyr1[l][idx];
  endfunction

  // monitor: pop expected items as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_en) begin
        nrd++;
        if (rdseen[rd_addr]) dupr++;
        rdseen[rd_addr] = 1'b1;
      end
      if (wr_en) begin
        nwr++;
        if (expq.size() == 0) chk("R3 write beyond expected sequence", 1, 0);
        else begin
          e_m = expq.pop_front();
          chk("R3/R4 level", int'(wr_level), int'(e_m[31:24]));
          chk("R4 address", int'(wr_addr), int'(e_m[23:8]));
          chk({dtag, " value"}, int'(wr_data), int'(e_m[7:0]));
        end
      end
      if (done) begin
        ndone++;
        chk("R6 done right after top write", int'(prev_top), 1);
        chk("R5 grid levels all written before done", expq.size(), 0);
      end
      prev_top = wr_en && (int'(wr_level) == TOPL);

      if (wr_en1) begin
        nwr1++;
        if (expq1.size() == 0) chk("R10 write beyond expected sequence", 1, 0);
        else begin
          e_m1 = expq1.pop_front();
          chk("R10 level", int'(wr_level1), int'(e_m1[31:24]));
          chk("R10 address", int'(wr_addr1), int'(e_m1[23:8]));
          chk("R10 value", int'(wr_data1), int'(e_m1[7:0]));
        end
      end
      if (done1) begin
        ndone1++;
        chk("R10 done right after 1x1 write", int'(prev_top1), 1);
      end
      prev_top1 = wr_en1 && (int'(wr_level1) == LT);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd = 1'b1;
  end

  task automatic fill(input int pat);
    for (int y = 0; y < IMG; y++) begin
      for (int x = 0; x < IMG; x++) begin
        int v;
        case (pat)
          0: v = (x * 7 + y * 3) & 255;
          1: v = 255;
          2: v = ((x & 1) && (y & 1)) ? 2 : (((x + y) % 4 == 0) ? 1 : 0);
          default: begin
            seed = seed * 1103515245 + 12345;
            v = (seed >> 16) & 255;
          end
        endcase
        img[y * IMG + x] = 8'(v);
      end
    end
  endtask

  // driver: independent pyramid model and expected write order
  task automatic build_expect();
    for (int l = 1; l <= TOPL; l++) begin
      int w  = IMG >> l;
      int wi = IMG >> (l - 1);
      for (int y = 0; y < w; y++)
        for (int x = 0; x < w; x++)
          pyr[l][y * w + x] = avg4(px(l - 1, 2 * y * wi + 2 * x), px(l - 1, 2 * y * wi + 2 * x + 1),
                                   px(l - 1, (2 * y + 1) * wi + 2 * x), px(l - 1, (2 * y + 1) * wi + 2 * x + 1));
    end
    for (int t = 0; t < NT; t++) begin
      int tx = t % GR;
      int ty = t / GR;
      for (int l = 1; l <= LT; l++) begin
        int e = TILE >> l;
        int w = IMG >> l;
        for (int oy = 0; oy < e; oy++)
          for (int ox = 0; ox < e; ox++) begin
            int a = (ty * e + oy) * w + tx * e + ox;
            expq.push_back({8'(l), 16'(a), 8'(pyr[l][a])});
          end
      end
    end
    for (int l = LT + 1; l <= TOPL; l++) begin
      int w = IMG >> l;
      for (int a = 0; a < w * w; a++) expq.push_back({8'(l), 16'(a), 8'(pyr[l][a])});
    end
    // single-tile instance sees img[0..TILE*TILE-1] as a TILE-wide image
    for (int l = 1; l <= LT; l++) begin
      int w  = TILE >> l;
      int wi = TILE >> (l - 1);
      for (int y = 0; y < w; y++)
        for (int x = 0; x < w; x++) begin
          pyr1[l][y * w + x] = avg4(px1(l - 1, 2 * y * wi + 2 * x), px1(l - 1, 2 * y * wi + 2 * x + 1),
                                    px1(l - 1, (2 * y + 1) * wi + 2 * x), px1(l - 1, (2 * y + 1) * wi + 2 * x + 1));
          expq1.push_back({8'(l), 16'(y * w + x), 8'(pyr1[l][y * w + x])});
        end
    end
  endtask

  task automatic run_frame(input int pat, input string tag, input bit poke);
    int total;
    total = 0;
    for (int l = 1; l <= TOPL; l++) total += (IMG >> l) * (IMG >> l);
    fill(pat);
    dtag = tag;
    build_expect();
    nwr = 0; nwr1 = 0; nrd = 0; dupr = 0; ndone = 0; ndone1 = 0;
    for (int i = 0; i < NPIX; i++) rdseen[i] = 1'b0;
    @(negedge clk);
    start = 1'b1; start1 = 1'b1;
    @(negedge clk);
    start = 1'b0; start1 = 1'b0;
    if (poke) begin
      repeat (500) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while ((ndone == 0 || ndone1 == 0) && !wd) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R9 image reads per frame", nrd, NPIX);
    chk("R9 no pixel read twice", dupr, 0);
    chk(poke ? "R7 write count with start while busy" : "R3 write count", nwr, total);
    chk("R6 one done per frame", ndone, 1);
    chk("R6 busy low after done", int'(busy), 0);
    chk("R10 single-tile write count", nwr1, (TILE * TILE - 1) / 3);
    chk("R10 single-tile done count", ndone1, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 busy after reset", int'(busy), 0);
    chk("R8 done after reset", int'(done), 0);
    chk("R8 wr_en after reset", int'(wr_en), 0);
    chk("R8 rd_en after reset", int'(rd_en), 0);
    run_frame(0, "R1 ramp", 1'b0);
    if (!wd) run_frame(1, "R2 saturated", 1'b0);
    if (!wd) run_frame(2, "R1 rounding", 1'b0);
    if (!wd) run_frame(3, "R5 random A", 1'b1);
    if (!wd) run_frame(4, "R5 random B", 1'b0);
    if (wd) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule